// File: doc/BRIEF.md
# Gated Rising-Edge Frequency Counter

The block counts rising edges of an asynchronous input over a gate window of a programmable number of system clocks. When a window closes, the count is latched as a result and a new window of the same length starts on the next clock. No clock is ever outside a window, so each result is a frequency reading: edges per window. A consumer reads the result while the valid flag is high and pulses the acknowledge input. A sticky flag shows that a result was overwritten before anyone acknowledged it.

A window length of zero selects free-running mode. In this mode there are no windows. The counter only accumulates, and the result output shows the live total at all times. Writing a new window length abandons the window in progress. The count is cleared and a fresh window starts.

Top module: `edge_meter`

## Requirements
- R1: Only rising edges of `pin_in` are counted. A level held high counts once. A `pin_in` value that first reads high at clock edge a is counted at edge a+2, which is the latency of the two synchronizer stages.
- R2: Suppose a non-zero length N is written at edge w. Windows then close at edges w+N, w+2N, and so on. At each close the count is latched into `result`, and counting continues with no lost clock. Between closes, `result` holds its value.
- R3: Suppose a counted edge falls on the same clock as a window close. That edge is left out of the closing result, and the new window starts at a count of 1. No edge is lost, and no edge is counted twice.
- R4: With a window length of 0, `result` shows the running count with no extra delay. The running count is never cleared by time, and `result_valid` is never set.
- R5: `result_valid` is set on the clock that latches a result. It stays set until an acknowledge.
- R6: When `read_ack` is high on a clock, `result_valid` and `overrun` are cleared. If that clock also closes a window, `result_valid` stays set for the new result and `overrun` is not set.
- R7: Suppose a window closes while `result_valid` is set and no acknowledge arrives. Then the new result replaces the old one, and `overrun` is set. `overrun` stays set until an acknowledge.
- R8: A write on `ivl_wr` clears the count on that clock and starts a new window. No result is latched on that clock.
- R9: After reset, `result` is 0, `result_valid` is 0, `overrun` is 0, and the block is in free-running mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous input whose rising edges are counted |
| ivl_wr | input | 1 | Write strobe for the window length |
| ivl_data | input | 32 | New window length in clocks (0 selects free-running) |
| read_ack | input | 1 | Acknowledge of the current result |
| result | output | 32 | Latched result, or live count in free-running mode |
| result_valid | output | 1 | An unacknowledged result is present |
| overrun | output | 1 | A result was overwritten before acknowledge (sticky) |

## Verification
Two pairs of events can fall in the same clock. The first pair is a counted input edge and a window close. The bench provokes this by driving a square wave whose period equals the window length, and by sweeping its phase over every offset of the window. At one offset the edge is always counted on the close. Each result is compared against an independent edge-and-window model, and the bench counts how many coincidences the model saw. The second pair is an acknowledge and a window close. The bench times an acknowledge to land exactly on a close, then checks that the new result is still flagged valid and that `overrun` is left clear.

// File: rtl/edge_meter_pkg.sv
package edge_meter_pkg;

    typedef enum logic {
        MODE_FREE  = 1'b0,
        MODE_GATED = 1'b1
    } meter_mode_e;

    // Events produced by the gate timer for the accumulator
    typedef struct packed {
        logic tick;     // window closes on this clock
        logic restart;  // new length written: abandon window
    } gate_evt_t;

    // Flags kept beside the latched result
    typedef struct packed {
        logic valid;
        logic overrun;
    } res_flags_t;

    function automatic meter_mode_e mode_of(input logic nonzero);
        return nonzero ? MODE_GATED : MODE_FREE;
    endfunction

endpackage

// File: rtl/em_pin_sync.sv
module em_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise
);
    localparam int CHAIN_W = STAGES + 1;

    // chain[0..STAGES-1]: synchronizer, chain[STAGES]: previous level
    logic [CHAIN_W-1:0] chain;

    generate
        for (genvar i = 0; i < CHAIN_W; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign rise = chain[STAGES-1] & ~chain[STAGES];

    // R1: a rising edge is a single-clock event
    assert_single_rise_R1: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/em_gate_timer.sv
module em_gate_timer
    import edge_meter_pkg::*;
#(
    parameter int IVL_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ivl_wr,
    input  logic [IVL_W-1:0] ivl_data,
    output gate_evt_t        evt,
    output meter_mode_e      mode
);
    localparam logic [IVL_W-1:0] ONE = IVL_W'(1);

    logic [IVL_W-1:0] ivl_q;
    logic [IVL_W-1:0] left_q;
    logic             at_end;

    assign mode   = mode_of(ivl_q != '0);
    assign at_end = (left_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ivl_q  <= '0;
            left_q <= '0;
        end else if (ivl_wr) begin
            ivl_q  <= ivl_data;
            left_q <= ivl_data - ONE;
        end else if (mode == MODE_GATED) begin
            // reload on terminal count: window length stays exact
            left_q <= at_end ? (ivl_q - ONE) : (left_q - ONE);
        end
    end

    always_comb begin
        evt.restart = ivl_wr;
        evt.tick    = (mode == MODE_GATED) && at_end && !ivl_wr;
    end

    // R2: after a close the next window is a full N clocks long
    assert_reload_R2: assert property (@(posedge clk) disable iff (rst)
        evt.tick |=> (left_q == ivl_q - ONE));

    // R8: a write takes effect as the new window length
    assert_write_loads_R8: assert property (@(posedge clk) disable iff (rst)
        ivl_wr |=> (ivl_q == $past(ivl_data)));

endmodule

// File: rtl/em_edge_acc.sv
module em_edge_acc
    import edge_meter_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  gate_evt_t        evt,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || evt.restart) begin
            count <= '0;
        end else if (evt.tick) begin
            // edge-aware clear: a coinciding edge opens the new window
            count <= rise ? ONE : '0;
        end else if (rise) begin
            count <= count + ONE;
        end
    end

    assert_carry_edge_R3: assert property (@(posedge clk) disable iff (rst)
        evt.tick && rise && !evt.restart |=> (count == ONE));

    assert_clean_close_R3: assert property (@(posedge clk) disable iff (rst)
        evt.tick && !rise && !evt.restart |=> (count == '0));

    assert_restart_clears_R8: assert property (@(posedge clk) disable iff (rst)
        evt.restart |=> (count == '0));

endmodule

// File: rtl/edge_meter.sv
module edge_meter
    import edge_meter_pkg::*;
#(
    parameter int IVL_W       = 32,
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_in,
    input  logic             ivl_wr,
    input  logic [IVL_W-1:0] ivl_data,
    input  logic             read_ack,
    output logic [CNT_W-1:0] result,
    output logic             result_valid,
    output logic             overrun
);
    logic             rise;
    gate_evt_t        evt;
    meter_mode_e      mode;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] res_q;
    res_flags_t       flags;

    em_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin  (pin_in),
        .rise (rise)
    );

    em_gate_timer #(.IVL_W(IVL_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .ivl_wr   (ivl_wr),
        .ivl_data (ivl_data),
        .evt      (evt),
        .mode     (mode)
    );

    em_edge_acc #(.CNT_W(CNT_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .rise  (rise),
        .evt   (evt),
        .count (count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (evt.tick) begin
            res_q <= count;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            // a close wins over an acknowledge on the same clock
            flags.valid   <= evt.tick | (flags.valid & ~read_ack);
            flags.overrun <= (evt.tick & flags.valid & ~read_ack)
                           | (flags.overrun & ~read_ack);
        end
    end

    assign result       = (mode == MODE_FREE) ? count : res_q;
    assign result_valid = flags.valid;
    assign overrun      = flags.overrun;

    assert_valid_on_close_R5: assert property (@(posedge clk) disable iff (rst)
        evt.tick |=> result_valid);

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
        read_ack && !evt.tick |=> !result_valid && !overrun);

    assert_ack_on_close_R6: assert property (@(posedge clk) disable iff (rst)
        read_ack && evt.tick |=> result_valid && !overrun);

    assert_overwrite_flag_R7: assert property (@(posedge clk) disable iff (rst)
        evt.tick && result_valid && !read_ack |=> overrun);

    assert_hold_result_R2: assert property (@(posedge clk) disable iff (rst)
        !evt.tick |=> $stable(res_q));

endmodule

// File: tb/edge_meter_bench.sv
module edge_meter_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        pin_in;
    logic        ivl_wr;
    logic [31:0] ivl_data;
    logic        read_ack;
    logic [31:0] result;
    logic        result_valid;
    logic        overrun;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    // model state
    logic        p1, p2, p3, m_rise;
    logic [31:0] m_ivl, m_left, m_cnt;
    int          last_tick = 0;
    int          coin_n    = 0;
    logic [31:0] exp_q[$];

    logic auto_ack = 1'b1;
    int   ack_at   = -100;
    bit   done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_meter u_edge_meter (
        .clk(clk), .rst(rst), .pin_in(pin_in), .ivl_wr(ivl_wr),
        .ivl_data(ivl_data), .read_ack(read_ack), .result(result),
        .result_valid(result_valid), .overrun(overrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // reference model: sync latency of two edges, window of N clocks
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            p1 = 0; p2 = 0; p3 = 0;
            m_ivl = 0; m_left = 0; m_cnt = 0;
        end else begin
            m_rise = p2 && !p3;
            p3 = p2; p2 = p1; p1 = pin_in;
            if (ivl_wr) begin
                m_ivl = ivl_data; m_left = ivl_data; m_cnt = 0;
            end else if (m_ivl != 0) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    exp_q.push_back(m_cnt);
                    if (m_rise) coin_n++;
                    m_cnt  = m_rise ? 32'd1 : 32'd0;
                    m_left = m_ivl;
                    last_tick = cyc;
                end else begin
                    m_cnt = m_cnt + {31'd0, m_rise};
                end
            end else begin
                m_cnt = m_cnt + {31'd0, m_rise};
            end
        end
    end

    // monitor: pops expected results and acknowledges
    always @(negedge clk) begin
        if (rst) begin
            read_ack = 1'b0;
        end else begin
            if (auto_ack && result_valid && !read_ack) begin
                if (exp_q.size() == 0) chk("R2 R5 unexpected result", 32'd1, 32'd0);
                else chk("R2 R3 result", result, exp_q.pop_front());
                read_ack = 1'b1;
            end else begin
                read_ack = (cyc == ack_at);
            end
        end
    end

    task automatic write_ivl(input logic [31:0] n);
        @(negedge clk); ivl_wr = 1'b1; ivl_data = n;
        @(negedge clk); ivl_wr = 1'b0;
    endtask

    task automatic pulses(input int k, input int hi, input int lo);
        for (int i = 0; i < k; i++) begin
            pin_in = 1'b1; repeat (hi) @(negedge clk);
            pin_in = 1'b0; repeat (lo) @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; pin_in = 1'b0; ivl_wr = 1'b0; ivl_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 result", result, 0);
        chk("R9 valid", {31'd0, result_valid}, 0);
        chk("R9 overrun", {31'd0, overrun}, 0);

        // free-running mode
        pulses(5, 2, 3);
        repeat (4) @(negedge clk);
        chk("R1 five rises", result, 5);
        chk("R4 live count", result, m_cnt);
        pulses(3, 1, 2);
        repeat (4) @(negedge clk);
        chk("R4 never cleared", result, 8);
        pulses(1, 12, 3);
        repeat (4) @(negedge clk);
        chk("R1 long high counts once", result, 9);
        chk("R4 no valid", {31'd0, result_valid}, 0);

        // exact window timing
        write_ivl(12);
        begin
            int k = 0;
            while (!result_valid && k < 100) begin @(negedge clk); k++; end
            chk("R2 first close after N clocks", k, 12);
        end
        repeat (3) @(negedge clk);

        // continuous windows with a steady wave
        write_ivl(20);
        pulses(30, 2, 2);
        repeat (25) @(negedge clk);

        // phase sweep: wave period equals window
        for (int ph = 0; ph < 10; ph++) begin
            write_ivl(10);
            repeat (ph) @(negedge clk);
            pulses(6, 5, 5);
        end
        repeat (12) @(negedge clk);
        chk("R3 coincidence provoked", {31'd0, coin_n > 0}, 1);
        chk("R3 queue drained", exp_q.size(), 0);

        // abort by rewrite, observed in free mode
        write_ivl(40);
        pulses(5, 2, 2);
        write_ivl(0);
        chk("R8 count cleared", result, 0);
        write_ivl(40);
        pulses(4, 2, 2);
        write_ivl(8);
        repeat (20) @(negedge clk);
        chk("R8 queue drained", exp_q.size(), 0);

        // overwrite
        auto_ack = 1'b0;
        write_ivl(10);
        pulses(10, 2, 2);
        repeat (12) @(negedge clk);
        chk("R7 overrun set", {31'd0, overrun}, 1);
        chk("R5 valid held", {31'd0, result_valid}, 1);
        chk("R7 newest result", result, exp_q[$]);
        exp_q.delete();

        // acknowledge on the closing clock
        ack_at = last_tick + 19;
        while (cyc < ack_at + 1) @(negedge clk);
        chk("R6 valid kept on close", {31'd0, result_valid}, 1);
        chk("R6 overrun cleared", {31'd0, overrun}, 0);
        chk("R6 new result", result, exp_q[$]);
        ack_at = cyc + 1;
        repeat (2) @(negedge clk);
        chk("R6 ack clears valid", {31'd0, result_valid}, 0);
        chk("R6 ack overrun low", {31'd0, overrun}, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule